// File: doc/BRIEF.md
# Split/Joined Timer-Counter with Capture

This block is a timer/counter built from two equal-width halves that either run on their own or chain into one double-width counter. A reloadable prescaler divides the cycles on which the system clock enable is high into timing steps. A two-flop synchronizer and a rising-edge detector turn an asynchronous event pin into single-cycle event steps. A two-bit mode chooses which step source drives each half and whether the halves are chained.

Each half, or the chained pair, counts up to a programmed match value. On the next step it returns to zero and raises a one-cycle interrupt pulse. Two capture strobes copy the running count into capture outputs. In the chained modes a single strobe captures the full double-width value. All configuration goes through one write port that selects a target register with a two-bit select.

Top module: `split_timer`

## Requirements
- R1: While rst_ni is low and after its release, cap_lo_o and cap_hi_o are zero and irq_lo_o and irq_hi_o are low until a count event occurs.
- R2: With prescaler reload P, one timing step is produced for every P+1 clock cycles in which tick_en_i is high. Cycles with tick_en_i low advance neither the prescaler nor any timing-driven counter.
- R3: Mode 0 (mode value 0): both halves count timing steps, each against its own match register.
- R4: Mode 1 (mode value 1): the low half counts timing steps and the high half counts event steps.
- R5: Mode 2 (mode value 2): the halves form one double-width counter of timing steps, with the high half above the low half, and a carry passes from low to high when the low half is all ones.
- R6: Mode 3 (mode value 3): the halves form one double-width counter of event steps, and tick_en_i and the prescaler have no effect on it.
- R7: When a half in a split mode (0 or 1) holds its match value and a step arrives, the half goes to zero on that edge and its flag (irq_lo_o for the low half, irq_hi_o for the high half) is high for exactly the following cycle.
- R8: In modes 2 and 3, irq_lo_o stays low. The wrap to zero and the irq_hi_o pulse occur on a step taken while the full count equals {match_hi, match_lo}.
- R9: evt_i passes through two synchronizer flops, and each low-to-high transition (at least one cycle high and one low) counts exactly once, whatever the high time.
- R10: A rising edge on cap_lo_i copies the low count, as it stood before that edge, into cap_lo_o. In split modes, cap_hi_i does the same for the high half into cap_hi_o. The capture outputs hold their value at all other times.
- R11: In modes 2 and 3, a rising edge on cap_lo_i captures the full count into {cap_hi_o, cap_lo_o}, and cap_hi_i is ignored.
- R12: Write select 0 loads match_lo, 1 loads match_hi, 2 loads the prescaler reload, and 3 loads the mode from wr_data_i[1:0]. A mode write clears both halves and the prescaler and suppresses flags on that edge. Match and reload writes leave the count running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_en_i | input | 1 | Clock enable feeding the prescaler |
| evt_i | input | 1 | Asynchronous external event pin |
| cap_lo_i | input | 1 | Low-half capture strobe (full capture in modes 2 and 3) |
| cap_hi_i | input | 1 | High-half capture strobe (split modes only) |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 match_lo, 1 match_hi, 2 reload, 3 mode |
| wr_data_i | input | HALF_W | Write data |
| irq_lo_o | output | 1 | Low-half match pulse |
| irq_hi_o | output | 1 | High-half or full match pulse |
| cap_lo_o | output | HALF_W | Captured low half |
| cap_hi_o | output | HALF_W | Captured high half |

## Verification
The bench uses the default parameters: an 8-bit half and two synchronizer stages. With these values a chained count crosses the 0xFF carry boundary and wraps at a 16-bit match above 256 within a few hundred cycles. Short match values give several wraps per vector, which exercises the flag pulses in every mode. Directed tests cover event-width independence, prescaler freezing, clearing on a mode write, and which strobe captures in each mode.

// File: rtl/split_timer_pkg.sv
package split_timer_pkg;
  typedef enum logic [1:0] {
    MODE_SPLIT_TT = 2'd0,
    MODE_SPLIT_TE = 2'd1,
    MODE_JOIN_T   = 2'd2,
    MODE_JOIN_E   = 2'd3
  } tmode_e;

  typedef enum logic [1:0] {
    SEL_MATCH_LO = 2'd0,
    SEL_MATCH_HI = 2'd1,
    SEL_RELOAD   = 2'd2,
    SEL_MODE     = 2'd3
  } wsel_e;
endpackage

// File: rtl/edge_rise.sv
module edge_rise #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  output logic rise_o
);
  logic sampled;
  logic prev_q;

  if (STAGES == 0) begin : g_direct
    assign sampled = in_i;
  end else begin : g_sync
    logic [STAGES-1:0] sync_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q <= '0;
      else         sync_q <= (sync_q << 1) | STAGES'(in_i);
    end
    assign sampled = sync_q[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sampled;
  end

  assign rise_o = sampled & ~prev_q;
endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] reload_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == reload_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (en_i)   cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/half_counter.sv
module half_counter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  input  logic         wrap_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (inc_i)  cnt_o <= wrap_i ? '0 : cnt_o + 1'b1;
  end
endmodule

// File: rtl/split_timer.sv
module split_timer
  import split_timer_pkg::*;
#(
  parameter int HALF_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_en_i,
  input  logic              evt_i,
  input  logic              cap_lo_i,
  input  logic              cap_hi_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [HALF_W-1:0] wr_data_i,
  output logic              irq_lo_o,
  output logic              irq_hi_o,
  output logic [HALF_W-1:0] cap_lo_o,
  output logic [HALF_W-1:0] cap_hi_o
);
  localparam int NHALF  = 2;
  localparam int FULL_W = NHALF * HALF_W;

  tmode_e            mode_q;
  logic [HALF_W-1:0] match_q [NHALF];
  logic [HALF_W-1:0] reload_q;
  logic              mode_wr;
  logic              step_t;
  logic              evt_step;
  logic              cap_lo_rise;
  logic              cap_hi_rise;
  logic              joined;
  logic              join_step;
  logic              full_hit;
  logic [HALF_W-1:0] cnt  [NHALF];
  logic              inc  [NHALF];
  logic              wrap [NHALF];
  logic [HALF_W-1:0] cnt_lo;
  logic [HALF_W-1:0] cnt_hi;

  assign mode_wr = wr_en_i && (wsel_e'(wr_sel_i) == SEL_MODE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_SPLIT_TT;
      reload_q <= '0;
      for (int i = 0; i < NHALF; i++) match_q[i] <= '1;
    end else if (wr_en_i) begin
      unique case (wsel_e'(wr_sel_i))
        SEL_MATCH_LO: match_q[0] <= wr_data_i;
        SEL_MATCH_HI: match_q[1] <= wr_data_i;
        SEL_RELOAD:   reload_q   <= wr_data_i;
        SEL_MODE:     mode_q     <= tmode_e'(wr_data_i[1:0]);
        default: ;
      endcase
    end
  end

  tick_prescaler #(.W(HALF_W)) u_pre (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (mode_wr),
    .en_i     (tick_en_i),
    .reload_i (reload_q),
    .tick_o   (step_t)
  );

  edge_rise #(.STAGES(SYNC_STAGES)) u_evt (
    .clk_i (clk_i), .rst_ni (rst_ni), .in_i (evt_i), .rise_o (evt_step)
  );
  edge_rise #(.STAGES(0)) u_cap_lo (
    .clk_i (clk_i), .rst_ni (rst_ni), .in_i (cap_lo_i), .rise_o (cap_lo_rise)
  );
  edge_rise #(.STAGES(0)) u_cap_hi (
    .clk_i (clk_i), .rst_ni (rst_ni), .in_i (cap_hi_i), .rise_o (cap_hi_rise)
  );

  assign joined    = mode_q[1];
  assign join_step = (mode_q == MODE_JOIN_T) ? step_t : evt_step;
  assign full_hit  = ({cnt[1], cnt[0]} == {match_q[1], match_q[0]});

  // step routing per mode
  always_comb begin
    inc[0]  = step_t;
    inc[1]  = step_t;
    wrap[0] = (cnt[0] == match_q[0]);
    wrap[1] = (cnt[1] == match_q[1]);
    unique case (mode_q)
      MODE_SPLIT_TT: ;
      MODE_SPLIT_TE: inc[1] = evt_step;
      MODE_JOIN_T, MODE_JOIN_E: begin
        inc[0]  = join_step;
        wrap[0] = full_hit;
        inc[1]  = join_step && ((&cnt[0]) || full_hit);
        wrap[1] = full_hit;
      end
      default: ;
    endcase
  end

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    half_counter #(.W(HALF_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (mode_wr),
      .inc_i  (inc[h]),
      .wrap_i (wrap[h]),
      .cnt_o  (cnt[h])
    );
  end

  assign cnt_lo = cnt[0];
  assign cnt_hi = cnt[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_lo_o <= 1'b0;
      irq_hi_o <= 1'b0;
    end else begin
      irq_lo_o <= !mode_wr && !joined && inc[0] && wrap[0];
      irq_hi_o <= !mode_wr && inc[1] && wrap[1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_lo_o <= '0;
      cap_hi_o <= '0;
    end else begin
      if (cap_lo_rise) begin
        cap_lo_o <= cnt[0];
        if (joined) cap_hi_o <= cnt[1];
      end
      if (cap_hi_rise && !joined) cap_hi_o <= cnt[1];
    end
  end

  logic [FULL_W-1:0] unused_full;
  assign unused_full = {cnt_hi, cnt_lo};
endmodule

// File: rtl/split_timer_checks.sv
module split_timer_checks #(
  parameter int HALF_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cap_lo_i,
  input logic              cap_hi_i,
  input logic              wr_en_i,
  input logic [1:0]        wr_sel_i,
  input logic              irq_lo_o,
  input logic              irq_hi_o,
  input logic [HALF_W-1:0] cap_lo_o,
  input logic [HALF_W-1:0] cap_hi_o,
  input logic [1:0]        mode_q,
  input logic [HALF_W-1:0] cnt_lo,
  input logic [HALF_W-1:0] cnt_hi,
  input logic              evt_step
);
  assert_lo_quiet_joined_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q[1] |-> !irq_lo_o);

  assert_cap_lo_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_lo_i |=> $stable(cap_lo_o));

  assert_cap_hi_joined_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q[1] && !cap_lo_i) |=> $stable(cap_hi_o));

  assert_mode_clear_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == 2'd3) |=>
      (cnt_lo == '0 && cnt_hi == '0 && !irq_lo_o && !irq_hi_o));

  assert_event_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_step |=> !evt_step);

  logic unused_hi;
  assign unused_hi = cap_hi_i;
endmodule

bind split_timer split_timer_checks #(.HALF_W(HALF_W)) u_checks (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cap_lo_i (cap_lo_i),
  .cap_hi_i (cap_hi_i),
  .wr_en_i  (wr_en_i),
  .wr_sel_i (wr_sel_i),
  .irq_lo_o (irq_lo_o),
  .irq_hi_o (irq_hi_o),
  .cap_lo_o (cap_lo_o),
  .cap_hi_o (cap_hi_o),
  .mode_q   (mode_q),
  .cnt_lo   (cnt_lo),
  .cnt_hi   (cnt_hi),
  .evt_step (evt_step)
);

// File: tb/tb_split_timer.sv
module tb_split_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       evt = 1'b0;
  logic       cap_lo = 1'b0;
  logic       cap_hi = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       irq_lo, irq_hi;
  logic [7:0] cap_lo_v, cap_hi_v;

  int n_chk = 0;
  int n_bad = 0;
  int n_lo = 0;
  int n_hi = 0;

  always #5 clk = ~clk;

  split_timer dut (
    .clk_i (clk), .rst_ni (rst_n), .tick_en_i (tick_en), .evt_i (evt),
    .cap_lo_i (cap_lo), .cap_hi_i (cap_hi), .wr_en_i (wr_en),
    .wr_sel_i (wr_sel), .wr_data_i (wr_data), .irq_lo_o (irq_lo),
    .irq_hi_o (irq_hi), .cap_lo_o (cap_lo_v), .cap_hi_o (cap_hi_v)
  );

  always @(negedge clk) if (rst_n) begin
    if (irq_lo) n_lo++;
    if (irq_hi) n_hi++;
  end

  typedef struct packed {
    logic [1:0]  mode;
    logic [7:0]  pre;
    logic [7:0]  mlo;
    logic [7:0]  mhi;
    logic [15:0] k;
    logic [7:0]  elo;
    logic [7:0]  ehi;
    logic [7:0]  nlo;
    logic [7:0]  nhi;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 8'd0, 8'd9,   8'd4,   16'd23,  8'd3,    8'd3,    8'd2, 8'd4},
    '{2'd0, 8'd3, 8'd255, 8'd2,   16'd40,  8'd10,   8'd1,    8'd0, 8'd3},
    '{2'd1, 8'd1, 8'd6,   8'd255, 16'd30,  8'd1,    8'd0,    8'd2, 8'd0},
    '{2'd2, 8'd0, 8'd255, 8'd255, 16'd300, 8'h2C,   8'h01,   8'd0, 8'd0},
    '{2'd2, 8'd1, 8'd16,  8'd0,   16'd80,  8'd6,    8'd0,    8'd0, 8'd2},
    '{2'd2, 8'd0, 8'd5,   8'd1,   16'd600, 8'h4C,   8'h00,   8'd0, 8'd2}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk);
    if (sel == 2'd3) begin n_lo = 0; n_hi = 0; end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic capture(input logic lo, input logic hi);
    tick_en = 1'b0; cap_lo = lo; cap_hi = hi;
    @(negedge clk);
    cap_lo = 1'b0; cap_hi = 1'b0;
    @(negedge clk);
  endtask

  task automatic evt_pulse(input int h, input int l);
    evt = 1'b1;
    repeat (h) @(negedge clk);
    evt = 1'b0;
    repeat (l) @(negedge clk);
  endtask

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'd0: return "R3";
      2'd1: return "R4";
      2'd2: return "R5";
      default: return "R6";
    endcase
  endfunction

  initial begin
    #2ms;
    $display("FAIL watchdog (R1..): got timeout expected completion");
    n_bad++;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 cap_lo", 16'(cap_lo_v), 16'd0);
    check("R1 cap_hi", 16'(cap_hi_v), 16'd0);
    check("R1 irq", 16'({irq_lo, irq_hi}), 16'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // vector table: R2 R3 R4 R5 R7 R8 R10 R11
    for (int v = 0; v < NV; v++) begin
      tick_en = 1'b1;
      wr(2'd0, VECS[v].mlo);
      wr(2'd1, VECS[v].mhi);
      wr(2'd2, VECS[v].pre);
      wr(2'd3, {6'd0, VECS[v].mode});
      repeat (int'(VECS[v].k)) @(negedge clk);
      capture(1'b1, !VECS[v].mode[1]);
      check(mode_tag(VECS[v].mode), 16'(cap_lo_v), 16'(VECS[v].elo));
      check(VECS[v].mode[1] ? "R11" : "R10", 16'(cap_hi_v), 16'(VECS[v].ehi));
      check(VECS[v].mode[1] ? "R8" : "R7", 16'(n_lo), 16'(VECS[v].nlo));
      check(VECS[v].mode[1] ? "R8" : "R7", 16'(n_hi), 16'(VECS[v].nhi));
    end

    // R2: tick_en low freezes prescaler
    tick_en = 1'b1;
    wr(2'd0, 8'd255); wr(2'd1, 8'd255); wr(2'd2, 8'd2); wr(2'd3, 8'd0);
    repeat (6) @(negedge clk);
    tick_en = 1'b0;
    repeat (5) @(negedge clk);
    tick_en = 1'b1;
    repeat (3) @(negedge clk);
    capture(1'b1, 1'b1);
    check("R2 lo", 16'(cap_lo_v), 16'd3);
    check("R2 hi", 16'(cap_hi_v), 16'd3);

    // R9: mode 1 events of varied widths
    tick_en = 1'b0;
    wr(2'd0, 8'd255); wr(2'd1, 8'd3); wr(2'd2, 8'd0); wr(2'd3, 8'd1);
    evt_pulse(1, 1); evt_pulse(3, 2); evt_pulse(1, 4); evt_pulse(6, 1); evt_pulse(2, 2);
    repeat (5) @(negedge clk);
    capture(1'b1, 1'b1);
    check("R9 hi", 16'(cap_hi_v), 16'd1);
    check("R9 lo", 16'(cap_lo_v), 16'd0);
    check("R9 irq_hi", 16'(n_hi), 16'd1);
    check("R9 irq_lo", 16'(n_lo), 16'd0);

    // R6: mode 3 ignores ticks
    tick_en = 1'b1;
    wr(2'd0, 8'd2); wr(2'd1, 8'd0); wr(2'd2, 8'd0); wr(2'd3, 8'd3);
    for (int e = 0; e < 7; e++) evt_pulse(2, 2);
    repeat (5) @(negedge clk);
    capture(1'b1, 1'b0);
    check("R6 lo", 16'(cap_lo_v), 16'd1);
    check("R6 hi", 16'(cap_hi_v), 16'd0);
    check("R6 irq_hi", 16'(n_hi), 16'd2);
    check("R8 irq_lo", 16'(n_lo), 16'd0);

    // R11: cap_hi ignored when joined
    tick_en = 1'b1;
    wr(2'd0, 8'd255); wr(2'd1, 8'd255); wr(2'd3, 8'd2);
    repeat (20) @(negedge clk);
    capture(1'b1, 1'b0);
    check("R11 full lo", 16'(cap_lo_v), 16'd20);
    tick_en = 1'b1;
    repeat (10) @(negedge clk);
    capture(1'b0, 1'b1);
    check("R11 ignore lo", 16'(cap_lo_v), 16'd20);
    check("R11 ignore hi", 16'(cap_hi_v), 16'd0);

    // R10: lo strobe alone leaves cap_hi held
    tick_en = 1'b1;
    wr(2'd3, 8'd0);
    repeat (7) @(negedge clk);
    capture(1'b1, 1'b0);
    check("R10 lo", 16'(cap_lo_v), 16'd7);
    check("R10 hi hold", 16'(cap_hi_v), 16'd0);

    // R12: mode write clears counters and prescaler
    tick_en = 1'b1;
    wr(2'd2, 8'd3); wr(2'd3, 8'd0);
    repeat (2) @(negedge clk);
    wr(2'd3, 8'd0);
    repeat (3) @(negedge clk);
    capture(1'b1, 1'b1);
    check("R12 clear lo", 16'(cap_lo_v), 16'd0);
    check("R12 clear hi", 16'(cap_hi_v), 16'd0);

    // R12: match write keeps counting
    tick_en = 1'b1;
    wr(2'd2, 8'd0); wr(2'd3, 8'd0);
    repeat (5) @(negedge clk);
    wr(2'd0, 8'd200);
    repeat (2) @(negedge clk);
    capture(1'b1, 1'b0);
    check("R12 match write", 16'(cap_lo_v), 16'd8);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule